// File: doc/BRIEF.md
# Interrupt Pin Acceptance Engine

This block keeps the delivery state of every input pin of an interrupt redirection controller. It watches the pin lines, which arrive already polarity-corrected so that 1 means asserted. From the register file it takes each pin's mask bit, trigger mode and vector. It turns line activity, end-of-interrupt (EOI) messages and rewrites of an entry's low half into delivery requests. Each request carries only a pin number. A downstream dispatcher picks the destination from that number.

The block owns the remote-IRR bit of every pin and exports it so that the register file can show it on reads. Level pins are gated by remote IRR and fire again on an EOI if their line is still asserted. Edge pins fire on every rising edge. A pending bit per pin holds events until the single output slot is free. The slot is served lowest pin first and is held under a valid/ready handshake.

Top module: `irq_pin_accept`

## Requirements
- R1: A pin whose mask bit is 1 never gains a pending request, whatever its line does. A request for it already waiting in the pending bits is dropped while the mask is 1.
- R2: An unmasked edge-mode pin (mode bit 0) records one request for every rising edge of its line (0 in one cycle, 1 in the next), whatever its remote IRR.
- R3: An unmasked level-mode pin (mode bit 1) records a request on a rising edge only if its remote IRR is 0. Remote IRR becomes 1 in the same cycle, and while it stays 1 further rising edges are ignored.
- R4: An EOI clears remote IRR on every pin whose vector equals the EOI vector. Pins with other vectors keep their remote IRR.
- R5: On an EOI, a matching pin that is level-mode, unmasked and has its line asserted records a new request, and its remote IRR reads 1 again.
- R6: A low-half write strobe for a pin whose mode bit is 0 clears that pin's remote IRR.
- R7: A low-half write strobe for a pin other than pin 0 that is level-mode and unmasked, with remote IRR 0 and its line asserted, sets remote IRR and records a request. Pin 0 is not re-evaluated by the strobe.
- R8: Recorded requests are offered one per cycle, lowest pin number first, and no event is lost while the slot is busy. An event sampled at clock edge k is offered on req_valid after edge k+1 if the slot is free.
- R9: While req_valid is 1 and req_ready is 0, req_valid stays 1 and req_pin keeps its value.
- R10: After reset, no request is offered and every remote IRR bit is 0. Remote IRR is set when a request is recorded, before the dispatcher accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | NPINS | Polarity-corrected pin lines, 1 = asserted |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| cfg_level | input | NPINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector; pin i is at bits i*VEC_W upward |
| wr_lo_valid | input | 1 | Pulse: the low half of an entry was just rewritten (cfg_* already show the new values) |
| wr_lo_pin | input | IDX_W | Pin whose entry was rewritten |
| eoi_valid | input | 1 | Pulse: EOI message present |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| req_valid | output | 1 | Delivery request offered |
| req_ready | input | 1 | Dispatcher accepts the offered request |
| req_pin | output | IDX_W | Pin number of the offered request |
| rirr | output | NPINS | Remote IRR bit of every pin |

## Verification
Some rules are checked by assertions on every cycle. These are the per-pin transitions: mask suppression, edge recording, remote-IRR gating of level pins, EOI clear and re-fire, and both kinds of entry re-evaluation. The assertions also check that at most one pin is taken per cycle and that an offered request is held stable while stalled. Other behaviour shows only in the bench's scenarios, which compare the accepted pin sequence with a scoreboard. These are the lowest-first ordering across simultaneous events, the survival of an edge that arrives while the slot is stalled, and the exclusion of pin 0 from write re-evaluation. The same holds for the two-edge latency and for remote IRR reading 1 before acceptance.

// File: rtl/irq_accept_pkg.sv
// Package: shared constants and types for the pin acceptance engine.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_accept_pkg;

    localparam int DEF_PINS  = 8;
    localparam int DEF_VEC_W = 8;

    // Trigger mode as stored in one bit of each entry
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

endpackage

// File: rtl/irq_pin_cell.sv
// Module: irq_pin_cell
// Keeps the state of one pin: the sampled line, remote IRR and the pending bit.
// Decides whether a line edge, an EOI or an entry rewrite records a request.
// Assumes: line is polarity-corrected; cfg inputs already show the new entry
// in the cycle wr_hit is high; take is high only while pend is high.
module irq_pin_cell
    import irq_accept_pkg::*;
#(
    parameter int VEC_W    = DEF_VEC_W,
    parameter bit PIN_ZERO = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  logic             mask,
    input  logic             level_mode,
    input  logic [VEC_W-1:0] vector,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             wr_hit,
    input  logic             take,
    output logic             rirr,
    output logic             pend
);

    logic  line_q;
    logic  rirr_q;
    logic  pend_q;
    trig_e trig;
    logic  rise;
    logic  vec_hit;
    logic  fire_edge, fire_level, fire_eoi, fire_wr, fire_any;
    logic  rirr_set, rirr_clr;
    logic  rirr_d, pend_d;

    // Classify this cycle's events for the pin
    always_comb begin
        trig       = trig_e'(level_mode);
        rise       = line & ~line_q;
        vec_hit    = eoi_valid && (vector == eoi_vector);
        fire_edge  = !mask && (trig == TRIG_EDGE) && rise;
        fire_level = !mask && (trig == TRIG_LEVEL) && rise && !rirr_q;
        fire_eoi   = vec_hit && (trig == TRIG_LEVEL) && !mask && line;
        fire_wr    = !PIN_ZERO && wr_hit && (trig == TRIG_LEVEL) && !mask
                     && !rirr_q && line;
        fire_any   = fire_edge | fire_level | fire_eoi | fire_wr;
        rirr_set   = fire_level | fire_eoi | fire_wr;
        rirr_clr   = vec_hit | (wr_hit && (trig == TRIG_EDGE));
        rirr_d     = rirr_set | (rirr_q & ~rirr_clr);
        pend_d     = ((pend_q & ~take) | fire_any) & ~mask;
    end

    // Register the line sample, remote IRR and pending bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            rirr_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            line_q <= line;
            rirr_q <= rirr_d;
            pend_q <= pend_d;
        end
    end

    assign rirr = rirr_q;
    assign pend = pend_q;

    AST_MASK_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        mask |=> !pend_q); // R1
    AST_EDGE_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask && !level_mode && line && !line_q) |=> pend_q); // R2
    AST_LEVEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && rirr_q && !pend_q && !vec_hit) |=> !pend_q); // R3
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_hit && !(level_mode && !mask && line)) |=> !rirr_q); // R4
    AST_EOI_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_hit && level_mode && !mask && line) |=> (rirr_q && pend_q)); // R5
    AST_WR_EDGE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !level_mode) |=> !rirr_q); // R6
    AST_WR_REEVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!PIN_ZERO && wr_hit && level_mode && !mask && !rirr_q && line)
        |=> (rirr_q && pend_q)); // R7
    AST_PIN0_NO_REEVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (PIN_ZERO && wr_hit && !rirr_q && !(line && !line_q) && !vec_hit)
        |=> !rirr_q); // R7

endmodule

// File: rtl/irq_prio_pick.sv
// Module: irq_prio_pick
// Fixed-priority picker: returns the lowest set candidate as a one-hot
// vector and as an index.
// Assumes: NPINS >= 2; purely combinational.
module irq_prio_pick
    import irq_accept_pkg::*;
#(
    parameter int NPINS = DEF_PINS,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic [NPINS-1:0] cand,
    output logic [NPINS-1:0] grant_oh,
    output logic [IDX_W-1:0] grant_idx,
    output logic             any
);

    // Scan from the top so that the lowest candidate is written last and wins
    always_comb begin
        grant_oh  = '0;
        grant_idx = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                grant_oh  = '0;
                grant_oh[i] = 1'b1;
                grant_idx = IDX_W'(i);
            end
        end
        any = |cand;
    end

endmodule

// File: rtl/irq_req_stage.sv
// Module: irq_req_stage
// Output slot holding one delivery request under a valid/ready handshake.
// Assumes: load_any/load_idx come from the picker; 'free' tells the caller
// in which cycles a pick is consumed.
module irq_req_stage #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_any,
    input  logic [IDX_W-1:0] load_idx,
    output logic             free,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [IDX_W-1:0] req_pin
);

    logic             valid_q;
    logic [IDX_W-1:0] pin_q;

    // Slot can accept a new pick when empty or being drained this cycle
    assign free = !valid_q || req_ready;

    // Load the picked pin into the slot or keep holding it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pin_q   <= '0;
        end else if (free) begin
            valid_q <= load_any;
            if (load_any) begin
                pin_q <= load_idx;
            end
        end
    end

    assign req_valid = valid_q;
    assign req_pin   = pin_q;

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !req_ready) |=> (valid_q && $stable(pin_q))); // R9

endmodule

// File: rtl/irq_pin_accept.sv
// Module: irq_pin_accept (top)
// Per-pin edge/level interrupt acceptance: one irq_pin_cell per pin, a
// lowest-first picker and a single handshaked output slot.
// Assumes: pin lines are synchronous and polarity-corrected; the register
// file pulses wr_lo_valid in the cycle the new entry shows on cfg_*.
module irq_pin_accept
    import irq_accept_pkg::*;
#(
    parameter int NPINS = DEF_PINS,
    parameter int VEC_W = DEF_VEC_W,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       pin_level,
    input  logic [NPINS-1:0]       cfg_mask,
    input  logic [NPINS-1:0]       cfg_level,
    input  logic [NPINS*VEC_W-1:0] cfg_vector,
    input  logic                   wr_lo_valid,
    input  logic [IDX_W-1:0]       wr_lo_pin,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vector,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [IDX_W-1:0]       req_pin,
    output logic [NPINS-1:0]       rirr
);

    logic [NPINS-1:0] pend;
    logic [NPINS-1:0] cand;
    logic [NPINS-1:0] grant_oh;
    logic [NPINS-1:0] take;
    logic [NPINS-1:0] wr_hit;
    logic [IDX_W-1:0] grant_idx;
    logic             grant_any;
    logic             slot_free;

    // Decode the rewrite strobe to a per-pin hit
    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            wr_hit[i] = wr_lo_valid && (wr_lo_pin == IDX_W'(i));
        end
    end

    // Only unmasked pending pins compete; a pick is consumed when the slot is free
    assign cand = pend & ~cfg_mask;
    assign take = slot_free ? grant_oh : '0;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        irq_pin_cell #(
            .VEC_W    (VEC_W),
            .PIN_ZERO (g == 0)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .line       (pin_level[g]),
            .mask       (cfg_mask[g]),
            .level_mode (cfg_level[g]),
            .vector     (cfg_vector[g*VEC_W +: VEC_W]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .wr_hit     (wr_hit[g]),
            .take       (take[g]),
            .rirr       (rirr[g]),
            .pend       (pend[g])
        );
    end

    irq_prio_pick #(
        .NPINS (NPINS)
    ) u_pick (
        .cand      (cand),
        .grant_oh  (grant_oh),
        .grant_idx (grant_idx),
        .any       (grant_any)
    );

    irq_req_stage #(
        .IDX_W (IDX_W)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_any  (grant_any),
        .load_idx  (grant_idx),
        .free      (slot_free),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_pin   (req_pin)
    );

    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take)); // R8
    AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ((take & ~pend) == '0)); // R8
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~take & ~cfg_mask) != '0) |=> (pend != '0)); // R8

endmodule

// File: tb/irq_pin_accept_bench.sv
// Bench: scoreboard of expected accepted pins plus direct checks on rirr
// and on the absence of requests.
module irq_pin_accept_bench;

    localparam int NPINS = 8;
    localparam int VEC_W = 8;
    localparam int IDX_W = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NPINS-1:0]       pin_level = '0;
    logic [NPINS-1:0]       cfg_mask = '1;
    logic [NPINS-1:0]       cfg_level = '0;
    logic [NPINS*VEC_W-1:0] cfg_vector = '0;
    logic                   wr_lo_valid = 1'b0;
    logic [IDX_W-1:0]       wr_lo_pin = '0;
    logic                   eoi_valid = 1'b0;
    logic [VEC_W-1:0]       eoi_vector = '0;
    logic                   req_valid;
    logic                   req_ready = 1'b1;
    logic [IDX_W-1:0]       req_pin;
    logic [NPINS-1:0]       rirr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int unsigned exp_q[$];

    always #2 clk = ~clk;

    irq_pin_accept #(.NPINS(NPINS), .VEC_W(VEC_W)) u_irq_pin_accept (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .cfg_mask(cfg_mask),
        .cfg_level(cfg_level), .cfg_vector(cfg_vector),
        .wr_lo_valid(wr_lo_valid), .wr_lo_pin(wr_lo_pin),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .req_valid(req_valid), .req_ready(req_ready), .req_pin(req_pin),
        .rirr(rirr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance n edges, then settle 1 ns past the edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic expect_pin(input int p);
        exp_q.push_back(p);
    endtask

    task automatic check_idle(input string tag);
        check(req_valid == 1'b0, tag, req_valid, 0);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    // Monitor: compare every accepted request with the scoreboard
    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected request", int'(req_pin), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(req_pin) == e, "R8 accepted pin order", int'(req_pin), e);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NPINS; i++) cfg_vector[i*VEC_W +: VEC_W] = VEC_W'(8'h30 + i);
        cfg_vector[3*VEC_W +: VEC_W] = 8'h50;
        cfg_vector[4*VEC_W +: VEC_W] = 8'h50;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R10: reset state
        check(req_valid == 1'b0, "R10 no request after reset", req_valid, 0);
        check(rirr == '0, "R10 rirr clear after reset", int'(rirr), 0);

        // R1: masked pin toggling yields nothing
        for (int k = 0; k < 3; k++) begin
            pin_level[1] = 1'b1; step(1);
            pin_level[1] = 1'b0; step(2);
        end
        step(2);
        check_idle("R1 masked pin silent");

        // R2: edge pin, three pulses give three requests
        cfg_mask[1] = 1'b0;
        step(1);
        for (int k = 0; k < 3; k++) begin
            expect_pin(1);
            pin_level[1] = 1'b1; step(1);
            pin_level[1] = 1'b0; step(2);
        end
        step(3);
        check_idle("R2 edge pulses all delivered");

        // R3/R10: level pin sets rirr when recorded, before acceptance
        req_ready = 1'b0;
        cfg_level[2] = 1'b1; cfg_mask[2] = 1'b0;
        step(1);
        pin_level[2] = 1'b1;
        step(1);
        check(rirr[2] == 1'b1, "R10 rirr set with recording", rirr[2], 1);
        check(req_valid == 1'b0, "R8 not yet offered", req_valid, 0);
        step(1);
        check(req_valid == 1'b1 && req_pin == 3'd2, "R8 offered after second edge", int'(req_pin), 2);
        check(rirr[2] == 1'b1, "R10 rirr set before accept", rirr[2], 1);
        expect_pin(2);
        req_ready = 1'b1;
        step(2);
        pin_level[2] = 1'b0; step(2);
        pin_level[2] = 1'b1; step(4);
        check_idle("R3 edge ignored while rirr set");
        check(rirr[2] == 1'b1, "R3 rirr still set", rirr[2], 1);

        // R4/R5/R8: shared vector on pins 3 and 4
        cfg_level[3] = 1'b1; cfg_mask[3] = 1'b0;
        cfg_level[4] = 1'b1; cfg_mask[4] = 1'b0;
        step(1);
        expect_pin(3); expect_pin(4);
        pin_level[3] = 1'b1; pin_level[4] = 1'b1;
        step(5);
        check(exp_q.size() == 0, "R8 simultaneous level pins served", exp_q.size(), 0);
        check(rirr[4:3] == 2'b11, "R3 both rirr set", int'(rirr[4:3]), 3);
        pin_level[3] = 1'b0;
        step(2);
        expect_pin(4);
        eoi_valid = 1'b1; eoi_vector = 8'h50;
        step(1);
        eoi_valid = 1'b0;
        check(rirr[3] == 1'b0, "R4 matching pin cleared", rirr[3], 0);
        check(rirr[4] == 1'b1, "R5 asserted pin re-armed", rirr[4], 1);
        check(rirr[2] == 1'b1, "R4 other vector untouched", rirr[2], 1);
        step(4);
        check_idle("R5 refire delivered once");

        // R6: rewrite pin 2 to edge mode clears rirr, no request
        cfg_level[2] = 1'b0;
        wr_lo_valid = 1'b1; wr_lo_pin = 3'd2;
        step(1);
        wr_lo_valid = 1'b0;
        check(rirr[2] == 1'b0, "R6 edge rewrite clears rirr", rirr[2], 1'b0);
        step(3);
        check_idle("R6 no request from rewrite");
        pin_level[2] = 1'b0;

        // R7: unmask-by-rewrite of asserted level pin 5 fires
        cfg_level[5] = 1'b1; pin_level[5] = 1'b1;
        step(3);
        check_idle("R1 masked asserted level pin silent");
        expect_pin(5);
        cfg_mask[5] = 1'b0; wr_lo_valid = 1'b1; wr_lo_pin = 3'd5;
        step(1);
        wr_lo_valid = 1'b0;
        check(rirr[5] == 1'b1, "R7 rewrite sets rirr", rirr[5], 1);
        step(3);
        check_idle("R7 rewrite request delivered");

        // R7: pin 0 is not re-evaluated on rewrite
        cfg_level[0] = 1'b1; pin_level[0] = 1'b1;
        step(3);
        cfg_mask[0] = 1'b0; wr_lo_valid = 1'b1; wr_lo_pin = 3'd0;
        step(1);
        wr_lo_valid = 1'b0;
        step(3);
        check(rirr[0] == 1'b0, "R7 pin 0 rirr untouched", rirr[0], 0);
        check_idle("R7 pin 0 no request");

        // R8/R9: simultaneous edges under stall, plus an edge during stall
        cfg_mask[6] = 1'b0; cfg_mask[7] = 1'b0;
        req_ready = 1'b0;
        step(1);
        expect_pin(1); expect_pin(1); expect_pin(6); expect_pin(7);
        pin_level[7] = 1'b1; pin_level[6] = 1'b1; pin_level[1] = 1'b1;
        step(1);
        pin_level[7] = 1'b0; pin_level[6] = 1'b0; pin_level[1] = 1'b0;
        step(1);
        check(req_valid == 1'b1 && req_pin == 3'd1, "R8 lowest pin first", int'(req_pin), 1);
        pin_level[1] = 1'b1;
        step(1);
        pin_level[1] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check(req_valid == 1'b1, "R9 valid held in stall", req_valid, 1);
            check(req_pin == 3'd1, "R9 pin held in stall", int'(req_pin), 1);
            step(1);
        end
        req_ready = 1'b1;
        step(8);
        check_idle("R8 stalled edge not lost");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule